// File: doc/BRIEF.md
# Synchronous Burst Static Memory

A clocked memory model with a two-bit linear burst address counter, as found behind a cache data array. A chip enable, two address-load strobes (one driven from the processor side, one from the cache controller side), an advance input and two byte write strobes are all taken on the rising clock edge. From them the block decides, each cycle, whether to drop out of selection, load a fresh external address, step to the next word of the burst, or stay on the current word. Staying on the current word inserts wait states.

The two load strobes follow different write rules. A load through the processor-side strobe is always a read, whatever the byte strobes say. A load through the controller-side strobe, and every step or hold cycle, reads when both byte strobes are high and writes the enabled halves otherwise. Read data comes out in flow-through fashion: it is valid during the clock period that follows the edge that took the read. An asynchronous output enable gates the output drive. The tri-state pad is modelled as a data bus plus a drive-enable flag.

Top module: `burst_sram`

## Requirements
- R1: At a rising edge where `cs_n` is high and either `ld_cpu_n` or `ld_ctl_n` is low, the block goes idle: no storage location is written, and `q_drive` stays low for the following period.
- R2: At an edge where `cs_n` is low and `ld_cpu_n` is low, `addr` is loaded and the access is a read. This holds even when `wr_n` has bits low, and nothing is written.
- R3: At an edge where `cs_n` is low, `ld_cpu_n` is high and `ld_ctl_n` is low, `addr` is loaded. The access is a write if any bit of `wr_n` is low, otherwise a read.
- R4: At an edge with both load strobes high and `step_n` low during an active burst, the two lowest address bits advance by one modulo 4 and the upper bits stay fixed. The access type follows `wr_n`, and `cs_n` is ignored.
- R5: At an edge with both load strobes high and `step_n` high during an active burst, the address is held. The access type still follows `wr_n`, so writes and reads can repeat on the same word.
- R6: `wr_n[1]` gates the upper 9-bit half (bits 17:9) and `wr_n[0]` gates the lower half (bits 8:0). A write changes only the halves whose strobe is low.
- R7: `q_drive` is high only while the last access was a read and `oe_n` is low. It follows `oe_n` combinationally within the clock period, and it is low after a write.
- R8: From reset until the first read, `q_drive` is low, even with `oe_n` low.
- R9: After the block has gone idle, step and hold cycles perform no access (no write, no drive) until a load with `cs_n` low starts a new burst.
- R10: Read data for the location taken at an edge is on `q` during the period right after that edge, and reflects a write made to that location at any earlier edge.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Rising-edge clock |
| rst | input | 1 | Synchronous active-high reset |
| cs_n | input | 1 | Chip select, active low |
| ld_cpu_n | input | 1 | Processor-side address load strobe, active low, always a read |
| ld_ctl_n | input | 1 | Controller-side address load strobe, active low |
| step_n | input | 1 | Burst advance, active low |
| wr_n | input | 2 | Byte-half write strobes, active low (bit 1 upper, bit 0 lower) |
| oe_n | input | 1 | Asynchronous output enable, active low |
| addr | input | 10 | External word address |
| d | input | 18 | Write data |
| q | output | 18 | Read data |
| q_drive | output | 1 | High when `q` would be driven onto the bus |

## Verification
The assertions check on every cycle the decode outcomes: idle after a deselect, a read after a processor-side load, the modulo-4 step that leaves the upper bits alone, the frozen address on hold, and no access while idle. They also check that the drive flag never rises with `oe_n` high and is low right after reset. Only the bench scenarios can show the stored contents: wrap-around burst order seen through data values, byte-half merging, writes inserted by hold cycles, and a write attempted while idle leaving memory untouched. The asynchronous response of `q_drive` to `oe_n` in mid-period is also shown only by the bench.

// File: rtl/bsram_pkg.sv
package bsram_pkg;

    parameter int DATA_W  = 18;
    parameter int LANES   = 2;
    parameter int ADDR_W  = 10;
    parameter int BURST_W = 2;

    typedef enum logic [1:0] {
        OP_NONE  = 2'd0,
        OP_READ  = 2'd1,
        OP_WRITE = 2'd2
    } op_e;

    typedef enum logic [2:0] {
        CMD_IDLE   = 3'd0,
        CMD_LD_CPU = 3'd1,
        CMD_LD_CTL = 3'd2,
        CMD_STEP   = 3'd3,
        CMD_HOLD   = 3'd4
    } cmd_e;

    typedef struct packed {
        cmd_e cmd;
        logic load;
        logic move;
    } dec_t;

    // Priority: deselect, then processor load, then controller load, then step/hold.
    function automatic dec_t decode_cmd(input logic cs_n, input logic ld_cpu_n,
                                        input logic ld_ctl_n, input logic step_n);
        dec_t r;
        r.load = 1'b0;
        r.move = 1'b0;
        if (cs_n && (!ld_cpu_n || !ld_ctl_n)) begin
            r.cmd = CMD_IDLE;
        end else if (!ld_cpu_n) begin
            r.cmd  = CMD_LD_CPU;
            r.load = 1'b1;
        end else if (!ld_ctl_n) begin
            r.cmd  = CMD_LD_CTL;
            r.load = 1'b1;
        end else if (!step_n) begin
            r.cmd  = CMD_STEP;
            r.move = 1'b1;
        end else begin
            r.cmd = CMD_HOLD;
        end
        return r;
    endfunction

    function automatic op_e strobe_op(input logic [LANES-1:0] wr_n);
        return (&wr_n) ? OP_READ : OP_WRITE;
    endfunction

endpackage

// File: rtl/bsram_seq.sv
module bsram_seq
    import bsram_pkg::*;
#(
    parameter int AW    = ADDR_W,
    parameter int BW    = BURST_W,
    parameter int NLANE = LANES
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             cs_n,
    input  logic             ld_cpu_n,
    input  logic             ld_ctl_n,
    input  logic             step_n,
    input  logic [NLANE-1:0] wr_n,
    input  logic [AW-1:0]    addr,
    output logic [AW-1:0]    acc_addr,
    output logic [NLANE-1:0] acc_we,
    output op_e              op_q,
    output logic [AW-1:0]    addr_q
);

    localparam int UPPER_W = AW - BW;

    dec_t          dec;
    logic          active_q, active_d;
    logic [AW-1:0] base_q, base_d;
    logic [BW-1:0] cnt_q, cnt_d;
    op_e           op_d;

    always_comb begin
        dec      = decode_cmd(cs_n, ld_cpu_n, ld_ctl_n, step_n);
        active_d = active_q;
        base_d   = base_q;
        cnt_d    = cnt_q;
        op_d     = OP_NONE;
        case (dec.cmd)
            CMD_IDLE: begin
                active_d = 1'b0;
            end
            CMD_LD_CPU: begin
                active_d = 1'b1;
                base_d   = addr;
                cnt_d    = '0;
                op_d     = OP_READ;
            end
            CMD_LD_CTL: begin
                active_d = 1'b1;
                base_d   = addr;
                cnt_d    = '0;
                op_d     = strobe_op(wr_n);
            end
            default: begin
                if (active_q) begin
                    if (dec.move) cnt_d = cnt_q + 1'b1;
                    op_d = strobe_op(wr_n);
                end
            end
        endcase
        acc_addr = {base_d[AW-1 -: UPPER_W], base_d[BW-1:0] + cnt_d};
        acc_we   = (op_d == OP_WRITE) ? ~wr_n : '0;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            active_q <= 1'b0;
            base_q   <= '0;
            cnt_q    <= '0;
            op_q     <= OP_NONE;
            addr_q   <= '0;
        end else begin
            active_q <= active_d;
            base_q   <= base_d;
            cnt_q    <= cnt_d;
            op_q     <= op_d;
            if (op_d != OP_NONE) addr_q <= acc_addr;
        end
    end

    AST_IDLE_ON_DESELECT: assert property (@(posedge clk) disable iff (rst)
        (cs_n && (!ld_cpu_n || !ld_ctl_n)) |=> (op_q == OP_NONE)); // R1

    AST_CPU_LOAD_READS: assert property (@(posedge clk) disable iff (rst)
        (!cs_n && !ld_cpu_n) |=> (op_q == OP_READ && addr_q == $past(addr))); // R2

    AST_STEP_WRAPS: assert property (@(posedge clk) disable iff (rst)
        (active_q && ld_cpu_n && ld_ctl_n && !step_n) |=>
        (addr_q[BW-1:0] == $past(addr_q[BW-1:0]) + 1'b1 &&
         addr_q[AW-1:BW] == $past(addr_q[AW-1:BW]))); // R4

    AST_HOLD_KEEPS_ADDR: assert property (@(posedge clk) disable iff (rst)
        (active_q && ld_cpu_n && ld_ctl_n && step_n) |=> $stable(addr_q)); // R5

    AST_NO_ACCESS_IDLE: assert property (@(posedge clk) disable iff (rst)
        (!active_q && ld_cpu_n && ld_ctl_n) |=> (op_q == OP_NONE)); // R9

endmodule

// File: rtl/bsram_array.sv
module bsram_array #(
    parameter int DW    = 18,
    parameter int NLANE = 2,
    parameter int AW    = 10
) (
    input  logic             clk,
    input  logic [NLANE-1:0] we,
    input  logic [AW-1:0]    waddr,
    input  logic [DW-1:0]    wdata,
    input  logic [AW-1:0]    raddr,
    output logic [DW-1:0]    rdata
);

    localparam int LW    = DW / NLANE;
    localparam int DEPTH = 1 << AW;

    for (genvar g = 0; g < NLANE; g++) begin : g_lane
        logic [LW-1:0] mem [DEPTH];

        always_ff @(posedge clk) begin
            if (we[g]) mem[waddr] <= wdata[g*LW +: LW];
        end

        assign rdata[g*LW +: LW] = mem[raddr];
    end

endmodule

// File: rtl/burst_sram.sv
module burst_sram
    import bsram_pkg::*;
#(
    parameter int DW    = DATA_W,
    parameter int AW    = ADDR_W,
    parameter int BW    = BURST_W,
    parameter int NLANE = LANES
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             cs_n,
    input  logic             ld_cpu_n,
    input  logic             ld_ctl_n,
    input  logic             step_n,
    input  logic [NLANE-1:0] wr_n,
    input  logic             oe_n,
    input  logic [AW-1:0]    addr,
    input  logic [DW-1:0]    d,
    output logic [DW-1:0]    q,
    output logic             q_drive
);

    logic [AW-1:0]    acc_addr;
    logic [NLANE-1:0] acc_we;
    op_e              op_q;
    logic [AW-1:0]    addr_q;

    bsram_seq #(.AW(AW), .BW(BW), .NLANE(NLANE)) u_seq (
        .clk      (clk),
        .rst      (rst),
        .cs_n     (cs_n),
        .ld_cpu_n (ld_cpu_n),
        .ld_ctl_n (ld_ctl_n),
        .step_n   (step_n),
        .wr_n     (wr_n),
        .addr     (addr),
        .acc_addr (acc_addr),
        .acc_we   (acc_we),
        .op_q     (op_q),
        .addr_q   (addr_q)
    );

    bsram_array #(.DW(DW), .NLANE(NLANE), .AW(AW)) u_array (
        .clk   (clk),
        .we    (acc_we),
        .waddr (acc_addr),
        .wdata (d),
        .raddr (addr_q),
        .rdata (q)
    );

    // Output drive is asynchronous in oe_n; the access type is registered.
    assign q_drive = (op_q == OP_READ) && !oe_n;

    AST_OE_GATES_DRIVE: assert property (@(posedge clk) disable iff (rst)
        oe_n |-> !q_drive); // R7

    AST_RELEASED_AFTER_RESET: assert property (@(posedge clk) disable iff (rst)
        $fell(rst) |-> !q_drive); // R8

endmodule

// File: tb/sim_burst_sram.sv
module sim_burst_sram;

    localparam int DW = 18;
    localparam int AW = 10;
    localparam int HW = 9;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          cs_n = 1'b1, ld_cpu_n = 1'b1, ld_ctl_n = 1'b1, step_n = 1'b1;
    logic [1:0]    wr_n = 2'b11;
    logic          oe_n = 1'b0;
    logic [AW-1:0] addr = '0;
    logic [DW-1:0] d = '0;
    logic [DW-1:0] q;
    logic          q_drive;

    always #10 clk = ~clk;

    burst_sram u0 (
        .clk(clk), .rst(rst), .cs_n(cs_n), .ld_cpu_n(ld_cpu_n), .ld_ctl_n(ld_ctl_n),
        .step_n(step_n), .wr_n(wr_n), .oe_n(oe_n), .addr(addr), .d(d),
        .q(q), .q_drive(q_drive)
    );

    typedef struct {
        string         req;
        bit            en;
        bit            chk;
        logic [DW-1:0] data;
    } exp_t;

    exp_t exp_q[$];
    int   n_chk = 0;
    int   n_fail = 0;

    // Reference state built from the requirements.
    logic [HW-1:0] m_mem [2][1 << AW];
    bit            m_known [2][1 << AW];
    bit            m_act = 0;
    logic [AW-1:0] m_base = '0;
    logic [1:0]    m_cnt = '0;

    task automatic check(string req, logic [DW-1:0] act, logic [DW-1:0] expv);
        n_chk++;
        if (act !== expv) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", req, act, expv);
        end
    endtask

    // One bus cycle: drive at the falling edge, model the rising edge, push expectation.
    task automatic cyc(string req, bit c, bit lp, bit lc, bit st, logic [1:0] w,
                       logic [AW-1:0] a, logic [DW-1:0] dat, bit oe);
        int            op;
        logic [AW-1:0] ea;
        exp_t          e;
        @(negedge clk);
        cs_n = c; ld_cpu_n = lp; ld_ctl_n = lc; step_n = st; wr_n = w;
        addr = a; d = dat; oe_n = oe;
        op = 0;
        if (c && (!lp || !lc)) begin
            m_act = 0;
        end else if (!lp) begin
            m_act = 1; m_base = a; m_cnt = 0; op = 1;
        end else if (!lc) begin
            m_act = 1; m_base = a; m_cnt = 0; op = (w == 2'b11) ? 1 : 2;
        end else if (m_act) begin
            if (!st) m_cnt = m_cnt + 1'b1;
            op = (w == 2'b11) ? 1 : 2;
        end
        ea = {m_base[AW-1:2], m_base[1:0] + m_cnt};
        if (op == 2) begin
            for (int i = 0; i < 2; i++) begin
                if (!w[i]) begin
                    m_mem[i][ea]   = dat[i*HW +: HW];
                    m_known[i][ea] = 1;
                end
            end
        end
        e.req  = req;
        e.en   = (op == 1) && !oe;
        e.chk  = e.en && m_known[0][ea] && m_known[1][ea];
        e.data = {m_mem[1][ea], m_mem[0][ea]};
        exp_q.push_back(e);
    endtask

    // Monitor: sample a quarter period after each rising edge.
    initial begin
        forever begin
            @(posedge clk);
            #5;
            if (exp_q.size() > 0) begin
                exp_t e;
                e = exp_q.pop_front();
                check({e.req, " drive"}, {17'd0, q_drive}, {17'd0, e.en});
                if (e.chk) check({e.req, " data"}, q, e.data);
            end
        end
    end

    initial begin
        fork
            begin
                repeat (3) @(posedge clk);
                @(negedge clk);
                rst = 1'b0;
                @(posedge clk); #5;
                check("R8 released after reset", {17'd0, q_drive}, 18'd0);
                // Controller-side write burst at 0x0F2, wraps through 0F3, 0F0, 0F1.
                cyc("R3 ctl load write", 0, 1, 0, 1, 2'b00, 10'h0F2, 18'h11111, 0);
                cyc("R4 step write", 1, 1, 1, 0, 2'b00, 10'h3FF, 18'h22222, 0);
                cyc("R4 step write wrap", 0, 1, 1, 0, 2'b00, 10'h000, 18'h33333, 0);
                cyc("R4 step write", 0, 1, 1, 0, 2'b00, 10'h000, 18'h04444, 0);
                // Processor-side load with write strobes low must read.
                cyc("R2 R10 cpu load reads", 0, 0, 1, 1, 2'b00, 10'h0F2, 18'h3FFFF, 0);
                cyc("R4 step read", 0, 1, 1, 0, 2'b11, 10'h000, 18'h0, 0);
                cyc("R4 step read wrap", 0, 1, 1, 0, 2'b11, 10'h000, 18'h0, 0);
                cyc("R5 hold read", 0, 1, 1, 1, 2'b11, 10'h000, 18'h0, 0);
                cyc("R4 step read", 0, 1, 1, 0, 2'b11, 10'h000, 18'h0, 0);
                cyc("R2 cpu reread", 0, 0, 1, 1, 2'b11, 10'h0F2, 18'h0, 0);
                // Byte-half writes.
                cyc("R3 ctl write full", 0, 1, 0, 1, 2'b00, 10'h100, 18'h2AAAA, 0);
                cyc("R6 lower half write", 0, 1, 0, 1, 2'b10, 10'h100, 18'h15555, 0);
                cyc("R6 read merged", 0, 0, 1, 1, 2'b11, 10'h100, 18'h0, 0);
                cyc("R6 upper half write", 0, 1, 0, 1, 2'b01, 10'h100, 18'h00F0F, 0);
                cyc("R3 ctl load read", 0, 1, 0, 1, 2'b11, 10'h100, 18'h0, 0);
                // Hold cycle inserting a write, then read back.
                cyc("R3 ctl load read", 0, 1, 0, 1, 2'b11, 10'h200, 18'h0, 0);
                cyc("R5 hold write", 1, 1, 1, 1, 2'b00, 10'h000, 18'h1234A, 0);
                cyc("R5 hold read after write", 0, 1, 1, 1, 2'b11, 10'h000, 18'h0, 0);
                // Deselect, then attempted write while idle.
                cyc("R1 deselect cpu", 1, 0, 1, 1, 2'b11, 10'h0F1, 18'h0, 0);
                cyc("R9 idle step write", 0, 1, 1, 0, 2'b00, 10'h000, 18'h3FFFF, 0);
                cyc("R9 idle hold write", 0, 1, 1, 1, 2'b00, 10'h000, 18'h3FFFF, 0);
                cyc("R9 memory untouched", 0, 0, 1, 1, 2'b11, 10'h200, 18'h0, 0);
                cyc("R1 deselect ctl", 1, 1, 0, 1, 2'b00, 10'h200, 18'h3FFFF, 0);
                cyc("R1 R9 memory untouched", 0, 1, 0, 1, 2'b11, 10'h200, 18'h0, 0);
                // Output enable rules.
                cyc("R7 read with oe high", 0, 0, 1, 1, 2'b11, 10'h0F2, 18'h0, 1);
                cyc("R7 write releases", 0, 1, 0, 1, 2'b00, 10'h300, 18'h0ABCD, 0);
                cyc("R7 R10 read", 0, 0, 1, 1, 2'b11, 10'h300, 18'h0, 0);
                @(posedge clk); #7;
                oe_n = 1'b1; #1;
                check("R7 async release", {17'd0, q_drive}, 18'd0);
                oe_n = 1'b0; #1;
                check("R7 async drive", {17'd0, q_drive}, 18'd1);
                repeat (3) @(posedge clk);
                #6;
                check("R7 scoreboard drained", exp_q.size(), 0);
            end
            begin
                repeat (5000) @(posedge clk);
                n_chk++;
                n_fail++;
                $display("FAIL watchdog actual=timeout expected=completion");
            end
        join_any
        disable fork;
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

endmodule